// File: doc/BRIEF.md
# Dual 32-bit Programmable Timer

This peripheral holds two separate 32-bit up-counters, a low half and a high half. Each has its own period register and a two-bit run mode: off, single run, or repeating. One shared control word carries both mode fields. A global control word selects the timer arrangement and lets each half out of reset. When a running counter reaches its period, that half gives a one-cycle interrupt pulse. In repeating mode the counter then starts again from zero. In single-run mode it stops at the period and its mode field drops back to off.

The low half also compares its count with a compare register while it keeps counting. A match gives a pulse on the low interrupt line. A period of all ones in repeating mode turns a half into a free-running 32-bit time base, which software reads through the bus.

Software uses a single-cycle bus. A write strobe, an address and write data are sampled on the rising clock edge. Read data is a combinational function of the address and the current register state.

Top module: `dual_tmr`

## Requirements
- R1: After reset every register reads 0, except the compare register at 0x60, which reads 0xFFFFFFFF. Both interrupt outputs are low.
- R2: The registers sit at these offsets: low counter 0x10, high counter 0x14, low period 0x18, high period 0x1C, mode word 0x20, global control 0x24, compare 0x60. Global control keeps bits 3:0 and reads 0 elsewhere. Reads of any other offset return 0, and writes to other offsets change no register.
- R3: A half counts up by one per clock when three conditions hold: global control bits 3:2 equal 01, its release bit is 1 (bit 0 for the low half, bit 1 for the high half), and its mode field is 01 or 10. With mode 00 or 11 its counter holds its value.
- R4: A running half whose counter equals its period pulses its interrupt in the next cycle. In mode 10 (repeating) its counter is 0 in that same next cycle.
- R5: The mode word holds the low mode at bits 7:6 and the high mode at bits 23:22. All other bits read 0. In mode 01 (single run), a period match pulses the interrupt, the counter holds the period value, and the mode field reads 00 from the next cycle. A bus write to the mode word in that same cycle takes precedence.
- R6: A half whose release bit is 0 has its counter cleared to 0 and reads it as 0. Bus writes to its counter are ignored, and it gives no interrupt.
- R7: A bus write to a released half's counter loads the written value. The load takes precedence over counting in that cycle.
- R8: While the low half runs, a low counter equal to the compare register pulses the low interrupt in the next cycle, and counting continues.
- R9: With global control bits 3:2 not equal to 01, neither counter changes except by reset release or bus write, and no period interrupt occurs.
- R10: With the period 0xFFFFFFFF in repeating mode, the counter passes from 0xFFFFFFFF to 0 and gives an interrupt at that wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, sampled on the rising edge |
| addr | input | AW (8) | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address |
| irq_lo | output | 1 | Low half period or compare interrupt pulse |
| irq_hi | output | 1 | High half period interrupt pulse |

## Verification
The bench aims at these corner cases, each with the fault it would expose:
- The match at a period of zero and at 0xFFFFFFFF. A design that compared after incrementing would skip the wrap or overflow past it.
- A single run that must freeze at the period and clear its mode field. A wrong design would keep counting or leave the mode set.
- Writes to the mode word or the counter in the cycle of a match. A design with the wrong priority would lose the software value.
- Compare matches away from the period. A design that cleared the counter on a match would stall the time base.
- Halves held in reset, and timer-mode values other than 01. Here a faulty design would count or interrupt when it should be idle.

// File: rtl/dual_tmr.sv
module dual_tmr #(
  parameter int AW = 8,
  parameter logic [AW-1:0] CMP_OFS = AW'('h60)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          irq_lo,
  output logic          irq_hi
);
  localparam logic [AW-1:0] A_CNT0 = AW'('h10);
  localparam logic [AW-1:0] A_CNT1 = AW'('h14);
  localparam logic [AW-1:0] A_PER0 = AW'('h18);
  localparam logic [AW-1:0] A_PER1 = AW'('h1C);
  localparam logic [AW-1:0] A_MODE = AW'('h20);
  localparam logic [AW-1:0] A_GCR  = AW'('h24);
  localparam logic [1:0] M_ONE = 2'b01;
  localparam logic [1:0] M_REP = 2'b10;

  logic [31:0] cnt_q [2];
  logic [31:0] per_q [2];
  logic [1:0]  mode_q [2];
  logic [31:0] cmp_q;
  logic [3:0]  gcr_q;
  logic [1:0]  run, hit;
  logic        cmp_hit;

  always_comb begin
    for (int h = 0; h < 2; h++) begin
      run[h] = (gcr_q[3:2] == 2'b01) && gcr_q[h] &&
               (mode_q[h] == M_ONE || mode_q[h] == M_REP);
      hit[h] = (cnt_q[h] == per_q[h]);
    end
  end

  assign cmp_hit = run[0] && (cnt_q[0] == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int h = 0; h < 2; h++) begin
        cnt_q[h]  <= '0;
        per_q[h]  <= '0;
        mode_q[h] <= '0;
      end
      cmp_q  <= '1;
      gcr_q  <= '0;
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      for (int h = 0; h < 2; h++) begin
        if (!gcr_q[h])
          cnt_q[h] <= '0;
        else if (wr_en && addr == (h == 0 ? A_CNT0 : A_CNT1))
          cnt_q[h] <= wdata;
        else if (run[h])
          cnt_q[h] <= hit[h] ? ((mode_q[h] == M_ONE) ? cnt_q[h] : '0)
                             : cnt_q[h] + 32'd1;

        if (wr_en && addr == A_MODE)
          mode_q[h] <= (h == 0) ? wdata[7:6] : wdata[23:22];
        else if (run[h] && hit[h] && mode_q[h] == M_ONE)
          mode_q[h] <= 2'b00;

        if (wr_en && addr == (h == 0 ? A_PER0 : A_PER1))
          per_q[h] <= wdata;
      end
      if (wr_en && addr == A_GCR) gcr_q <= wdata[3:0];
      if (wr_en && addr == CMP_OFS) cmp_q <= wdata;
      irq_lo <= (run[0] && hit[0]) || cmp_hit;
      irq_hi <= run[1] && hit[1];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CNT0)       rdata = cnt_q[0];
    else if (addr == A_CNT1)  rdata = cnt_q[1];
    else if (addr == A_PER0)  rdata = per_q[0];
    else if (addr == A_PER1)  rdata = per_q[1];
    else if (addr == A_MODE)  rdata = {8'b0, mode_q[1], 14'b0, mode_q[0], 6'b0};
    else if (addr == A_GCR)   rdata = {28'b0, gcr_q};
    else if (addr == CMP_OFS) rdata = cmp_q;
  end
endmodule

// File: rtl/dual_tmr_chk.sv
module dual_tmr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  gcr,
  input logic [1:0]  mode_lo,
  input logic [31:0] cnt_lo,
  input logic [31:0] per_lo,
  input logic [31:0] cmp,
  input logic [31:0] cnt_hi,
  input logic        irq_lo,
  input logic        irq_hi
);
  logic lo_on;
  assign lo_on = (gcr[3:2] == 2'b01) && gcr[0] && (mode_lo == 2'b01 || mode_lo == 2'b10);

  a_r4_periodic_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    lo_on && mode_lo == 2'b10 && cnt_lo == per_lo && !wr_en |=> cnt_lo == 32'd0 && irq_lo);

  a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    lo_on && mode_lo == 2'b01 && cnt_lo == per_lo && !wr_en |=> mode_lo == 2'b00 && $stable(cnt_lo) && irq_lo);

  a_r6_held_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !gcr[1] |=> cnt_hi == 32'd0 && !irq_hi);

  a_r3_frozen_off: assert property (@(posedge clk) disable iff (!rst_n)
    gcr[0] && mode_lo == 2'b00 && !wr_en |=> $stable(cnt_lo));

  a_r8_cmp_match: assert property (@(posedge clk) disable iff (!rst_n)
    lo_on && cnt_lo == cmp && cnt_lo != per_lo && !wr_en |=> irq_lo && cnt_lo == $past(cnt_lo) + 32'd1);

  a_r9_mode_halt: assert property (@(posedge clk) disable iff (!rst_n)
    gcr[3:2] != 2'b01 && gcr[1] && !wr_en |=> $stable(cnt_hi) && !irq_hi);
endmodule

bind dual_tmr dual_tmr_chk u_dual_tmr_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .gcr(gcr_q), .mode_lo(mode_q[0]),
  .cnt_lo(cnt_q[0]), .per_lo(per_q[0]), .cmp(cmp_q), .cnt_hi(cnt_q[1]),
  .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/test_dual_tmr.sv
module test_dual_tmr;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        irq_lo, irq_hi;
  int          n_chk = 0, n_bad = 0;
  string       ph = "R1";

  logic [31:0] m_cnt [2];
  logic [31:0] m_per [2];
  logic [1:0]  m_mode [2];
  logic [31:0] m_cmp;
  logic [3:0]  m_gcr;
  logic        m_irq [2];

  always #4 clk = ~clk;

  dual_tmr i_dual_tmr (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_lo(irq_lo), .irq_hi(irq_hi));

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      8'h10: return m_cnt[0];
      8'h14: return m_cnt[1];
      8'h18: return m_per[0];
      8'h1C: return m_per[1];
      8'h20: return {8'b0, m_mode[1], 14'b0, m_mode[0], 6'b0};
      8'h24: return {28'b0, m_gcr};
      8'h60: return m_cmp;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rtag(input logic [7:0] a);
    case (a)
      8'h10, 8'h14: return "R3";
      8'h20: return "R5";
      8'h60: return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s/%s act=%h exp=%h t=%0t", ph, tag, act, exp, $time);
    end
  endtask

  task automatic model_clk(input logic w, input logic [7:0] a, input logic [31:0] d);
    logic [31:0] nc [2];
    logic [1:0]  nm [2];
    logic on, hit;
    for (int h = 0; h < 2; h++) begin
      on  = m_gcr[3:2] == 2'b01 && m_gcr[h] && (m_mode[h] == 2'b01 || m_mode[h] == 2'b10);
      hit = m_cnt[h] == m_per[h];
      m_irq[h] = (on && hit) || (h == 0 && on && m_cnt[0] == m_cmp);
      if (!m_gcr[h]) nc[h] = 0;
      else if (w && a == (h == 0 ? 8'h10 : 8'h14)) nc[h] = d;
      else if (on) nc[h] = hit ? (m_mode[h] == 2'b01 ? m_cnt[h] : 32'd0) : m_cnt[h] + 1;
      else nc[h] = m_cnt[h];
      if (w && a == 8'h20) nm[h] = (h == 0) ? d[7:6] : d[23:22];
      else if (on && hit && m_mode[h] == 2'b01) nm[h] = 2'b00;
      else nm[h] = m_mode[h];
    end
    for (int h = 0; h < 2; h++) begin
      m_cnt[h] = nc[h];
      m_mode[h] = nm[h];
      if (w && a == (h == 0 ? 8'h18 : 8'h1C)) m_per[h] = d;
    end
    if (w && a == 8'h24) m_gcr = d[3:0];
    if (w && a == 8'h60) m_cmp = d;
  endtask

  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d);
    wr_en = w; addr = a; wdata = d;
    #1 check(rtag(a), rdata, mread(a));
    @(posedge clk);
    model_clk(w, a, d);
    @(negedge clk);
    check("R8", {31'b0, irq_lo}, {31'b0, m_irq[0]});
    check("R4", {31'b0, irq_hi}, {31'b0, m_irq[1]});
  endtask

  task automatic idle(input logic [7:0] a, input int n);
    for (int i = 0; i < n; i++) step(0, a, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] alist [7];
    alist = '{8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h60};
    void'($urandom(32'd5150));
    for (int h = 0; h < 2; h++) begin
      m_cnt[h] = 0; m_per[h] = 0; m_mode[h] = 0; m_irq[h] = 0;
    end
    m_cmp = 32'hFFFF_FFFF; m_gcr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset values
    ph = "R1";
    foreach (alist[i]) step(0, alist[i], 0);
    step(0, 8'h00, 0);
    // R2: unmapped offset write and read
    ph = "R2";
    step(1, 8'h30, 32'hDEAD_BEEF);
    step(0, 8'h30, 0);
    foreach (alist[i]) step(0, alist[i], 0);
    // R10: free-running wrap
    ph = "R10";
    step(1, 8'h24, 32'h7);
    step(1, 8'h18, 32'hFFFF_FFFF);
    step(1, 8'h10, 32'hFFFF_FFFC);
    step(1, 8'h20, 32'h80);
    idle(8'h10, 8);
    // R5: single run on high half
    ph = "R5";
    step(1, 8'h1C, 32'd5);
    step(1, 8'h14, 32'd0);
    step(1, 8'h20, 32'h0040_0080);
    for (int i = 0; i < 6; i++) begin step(0, 8'h20, 0); step(0, 8'h14, 0); end
    // R8: compare match while counting
    ph = "R8";
    step(1, 8'h18, 32'd100);
    step(1, 8'h60, 32'd20);
    step(1, 8'h10, 32'd15);
    idle(8'h10, 10);
    // R7: counter load mid-run
    ph = "R7";
    step(1, 8'h10, 32'd98);
    idle(8'h10, 5);
    // R6: high half held in reset
    ph = "R6";
    step(1, 8'h20, 32'h0080_0080);
    step(1, 8'h24, 32'h5);
    step(1, 8'h14, 32'd7);
    idle(8'h14, 4);
    // R9: timer mode other than 01
    ph = "R9";
    step(1, 8'h24, 32'hF);
    idle(8'h10, 4);
    step(1, 8'h24, 32'h3);
    idle(8'h14, 4);
    // random phase
    ph = "RND";
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [31:0] v;
      op = $urandom % 16;
      case (op)
        0: begin
          v = ($urandom % 4 == 0) ? $urandom : (32'h4 | ($urandom % 4));
          step(1, 8'h24, v);
        end
        1: step(1, 8'h20, $urandom);
        2, 3: step(1, (op == 2) ? 8'h18 : 8'h1C,
                   ($urandom % 8 == 0) ? 32'hFFFF_FFFF : ($urandom % 32));
        4: step(1, ($urandom % 2) ? 8'h10 : 8'h14,
                ($urandom % 8 == 0) ? (32'hFFFF_FFF0 | ($urandom % 16)) : ($urandom % 32));
        5: step(1, 8'h60, $urandom % 32);
        6: step(1, 8'(8'h40 + ($urandom % 16)), $urandom);
        default: step(0, ($urandom % 8 == 7) ? 8'($urandom) : alist[$urandom % 7], 0);
      endcase
    end
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule